// File: doc/BRIEF.md
# Parallel Converter Host Controller

This block sits on the host side of a 16-bit sampling converter with a parallel output bus. After the host's own reset is released it pulses the converter's reset line low for a programmable number of cycles. It then watches the converter's active-low busy line: busy must go low shortly after reset is released, and it must return high within a bounded calibration window. If either step fails, the controller stops in a fault state. If both succeed, it enables the converter's output drivers and starts taking in one word per clock.

Each word is captured on the falling clock edge, half a cycle after the converter launches it on the rising edge. The word is converted from offset binary to two's complement and presented on a valid/data stream. Each stream beat carries an over-range tag and a settling tag. The over-range tag combines the converter's own flag with a check of the code against the edges of its usable code range. The settling tag marks the samples that still reflect the old gain while the converter pipeline drains. Gain is set through a one-cycle write strobe. The one forbidden gain encoding is refused and recorded in a sticky error flag.

Top module: `adc_host_ctrl`

## Requirements
- R1: While `rst_n` is low, `conv_rst_n`, `conv_oe`, `smp_valid`, `fault` and `gain_err` are low and `conv_gain` is 000. After release, `conv_rst_n` stays low for RST_CYC more rising edges (default 4, at least 3), then goes high.
- R2: After `conv_rst_n` rises, `conv_busy_n` must be sampled low on one of the next FALL_WIN (2) rising edges. Otherwise `fault` rises on the FALL_WIN-th edge and stays high until `rst_n` is asserted.
- R3: Once busy has been seen low, the controller enters run on the first edge that samples `conv_busy_n` high, provided this is within CAL_TIMEOUT edges. In run, `conv_oe` is high. If busy is still low on the CAL_TIMEOUT-th edge, `fault` rises instead.
- R4: `smp_valid` is high only in run. A word present on `conv_data` at a falling edge during run appears on the stream at the next rising edge, one beat per clock, in order.
- R5: `smp_data` is the captured word with bit 15 inverted. Offset-binary 0x0000, 0x8000 and 0xFFFF become 0x8000, 0x0000 and 0x7FFF.
- R6: `smp_ovr` is high when the captured `conv_ovr` is high, or the code is at least 0xFC00, or the code is at most 0x03FF.
- R7: A write strobe with a code from 000 to 110 updates `conv_gain` on the same edge. The codes 000 to 110 select 0, 3, 6, 12, 15, 18 and 20 dB in that order.
- R8: A write of code 111 leaves `conv_gain` unchanged, does not restart settling, and sets `gain_err`. `gain_err` then stays high until `rst_n` is asserted.
- R9: After an accepted gain write, the next six stream beats carry `smp_settle` high. The seventh and later beats carry it low until the next accepted write.
- R10: While `fault` is high, `conv_oe` and `smp_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; the converter samples on the same clock |
| rst_n | input | 1 | Synchronous active-low host reset |
| conv_rst_n | output | 1 | Active-low reset pulse to the converter |
| conv_busy_n | input | 1 | Converter calibration busy, active low |
| conv_oe | output | 1 | Converter output-bus enable, active high |
| conv_data | input | 16 | Offset-binary sample word from the converter |
| conv_ovr | input | 1 | Converter over-range flag |
| conv_gain | output | 3 | Gain select to the converter |
| gain_wr_en | input | 1 | One-cycle gain write strobe |
| gain_wr_data | input | 3 | Gain code to write |
| gain_err | output | 1 | Sticky flag: a forbidden gain code was written |
| smp_valid | output | 1 | Stream beat valid |
| smp_data | output | 16 | Two's-complement sample |
| smp_ovr | output | 1 | Over-range tag of the beat |
| smp_settle | output | 1 | Beat taken while a gain change was settling |
| fault | output | 1 | Startup handshake failed |

## Verification
The stream is driven with a fixed set of codes on and just inside the two over-range thresholds, with the zero and full-scale codes, and with a mid-scale word that carries only the converter's flag. These separate the code comparison from the flag path and show a wrong threshold or an off-by-one compare. Long runs of random words then check the bit-15 inversion and the beat ordering. Gain writes of every legal code, followed by the forbidden code, show whether the settling window counts exactly six beats and whether a refused write wrongly restarts it. The startup handshake is tried with busy falling on the first and the last allowed edge and one edge too late, and with calibration ending on the last allowed edge and one edge too late. This separates the fault timing from the run-entry timing.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the converter host controller.
// Assumes a 3-bit gain field in which one encoding is reserved.
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,       // converter held in reset
        ST_WAIT_BUSY,  // waiting for busy to assert
        ST_CALIB,      // converter calibrating, waiting for busy to clear
        ST_RUN,        // streaming samples
        ST_FAULT       // handshake failed, parked until host reset
    } seq_state_t;

    localparam int              GAIN_W      = 3;
    localparam logic [GAIN_W-1:0] GAIN_FORBID = 3'b111;

endpackage

// File: rtl/adc_host_seq.sv
`timescale 1ns/1ps
// Startup sequencer: pulses the converter reset, checks that busy asserts
// within FALL_WIN edges and clears within CAL_TIMEOUT edges, then enters run.
// Assumes conv_busy_n is synchronous to clk. All outputs are registered.
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int RST_CYC     = 4,
    parameter int FALL_WIN    = 2,
    parameter int CAL_TIMEOUT = 750000
)(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n,
    output logic conv_rst_n,
    output logic run,
    output logic fault
);

    localparam int CNT_W = $clog2(RST_CYC + FALL_WIN + CAL_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIM_HOLD = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_FALL = CNT_W'(FALL_WIN - 1);
    localparam logic [CNT_W-1:0] LIM_CAL  = CNT_W'(CAL_TIMEOUT - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // Next-state and phase-counter decision.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt + CNT_W'(1);
        case (state)
            ST_HOLD: begin
                if (cnt == LIM_HOLD) begin
                    nxt     = ST_WAIT_BUSY;
                    cnt_nxt = '0;
                end
            end
            ST_WAIT_BUSY: begin
                if (!busy_n) begin
                    nxt     = ST_CALIB;
                    cnt_nxt = '0;
                end else if (cnt == LIM_FALL) begin
                    nxt = ST_FAULT;
                end
            end
            ST_CALIB: begin
                if (busy_n) begin
                    nxt = ST_RUN;
                end else if (cnt == LIM_CAL) begin
                    nxt = ST_FAULT;
                end
            end
            ST_RUN:   cnt_nxt = cnt;
            ST_FAULT: cnt_nxt = cnt;
            default:  nxt = ST_FAULT;
        endcase
    end

    // State, counter and registered decodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HOLD;
            cnt        <= '0;
            conv_rst_n <= 1'b0;
            run        <= 1'b0;
            fault      <= 1'b0;
        end else begin
            state      <= nxt;
            cnt        <= cnt_nxt;
            conv_rst_n <= (nxt != ST_HOLD);
            run        <= (nxt == ST_RUN);
            fault      <= (nxt == ST_FAULT);
        end
    end

endmodule

// File: rtl/adc_host_gain.sv
`timescale 1ns/1ps
// Gain register: accepts legal codes and refuses the reserved code, which
// sets a sticky error. An accepted write arms a settling count of SETTLE
// stream beats; each emitted beat (fire) consumes one.
module adc_host_gain
    import adc_host_pkg::*;
#(
    parameter logic [GAIN_W-1:0] GAIN_INIT = '0,
    parameter int                SETTLE    = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GAIN_W-1:0] wr_code,
    input  logic              fire,
    output logic [GAIN_W-1:0] gain,
    output logic              gain_err,
    output logic              settling
);

    localparam int            SET_W = $clog2(SETTLE + 1);
    localparam logic [SET_W-1:0] SET_LOAD = SET_W'(SETTLE);

    logic             wr_ok, wr_bad;
    logic [SET_W-1:0] left;

    assign wr_ok  = wr_en && (wr_code != GAIN_FORBID);
    assign wr_bad = wr_en && (wr_code == GAIN_FORBID);

    // Hold the active gain code.
    always_ff @(posedge clk) begin
        if (!rst_n)     gain <= GAIN_INIT;
        else if (wr_ok) gain <= wr_code;
    end

    // Remember any refused write until host reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      gain_err <= 1'b0;
        else if (wr_bad) gain_err <= 1'b1;
    end

    // Count down the beats still affected by the last gain change.
    always_ff @(posedge clk) begin
        if (!rst_n)                     left <= '0;
        else if (wr_ok)                 left <= SET_LOAD;
        else if (fire && left != '0)    left <= left - SET_W'(1);
    end

    assign settling = (left != '0);

endmodule

// File: rtl/adc_host_capture.sv
`timescale 1ns/1ps
// Sample path: latches the converter bus on the falling edge (data launched on
// the rising edge), then on the next rising edge emits a two's-complement
// beat with an over-range tag and the current settling tag.
module adc_host_capture #(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] OVR_HI = 16'hFC00,
    parameter logic [DATA_W-1:0] OVR_LO = 16'h03FF
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_ovr,
    input  logic              settling,
    output logic              fire,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_ovr,
    output logic              smp_settle
);

    localparam int MSB = DATA_W - 1;

    logic              cap_vld;
    logic [DATA_W-1:0] cap_word;
    logic              cap_flag;
    logic [DATA_W-1:0] twos;
    logic              range_hit;

    // Falling-edge capture of the converter bus.
    always_ff @(negedge clk) begin
        if (!rst_n) cap_vld <= 1'b0;
        else        cap_vld <= run;
        cap_word <= conv_data;
        cap_flag <= conv_ovr;
    end

    // Offset binary to two's complement and range check.
    always_comb begin
        twos      = {~cap_word[MSB], cap_word[MSB-1:0]};
        range_hit = cap_flag || (cap_word >= OVR_HI) || (cap_word <= OVR_LO);
    end

    assign fire = cap_vld;

    // Rising-edge stream register.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_valid <= 1'b0;
        else        smp_valid <= cap_vld;
    end

    // Beat payload, loaded only when a captured word is valid.
    always_ff @(posedge clk) begin
        if (cap_vld) begin
            smp_data   <= twos;
            smp_ovr    <= range_hit;
            smp_settle <= settling;
        end
    end

endmodule

// File: rtl/adc_host_ctrl.sv
`timescale 1ns/1ps
// Converter host controller top: ties the startup sequencer, the gain register
// and the sample path together. Output enable follows the run state.
// Assumes one shared clock with the converter and synchronous active-low reset.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                RST_CYC     = 4,
    parameter int                FALL_WIN    = 2,
    parameter int                CAL_TIMEOUT = 750000,
    parameter int                SETTLE      = 6,
    parameter logic [GAIN_W-1:0] GAIN_INIT   = '0,
    parameter logic [DATA_W-1:0] OVR_HI      = 16'hFC00,
    parameter logic [DATA_W-1:0] OVR_LO      = 16'h03FF
)(
    input  logic              clk,
    input  logic              rst_n,
    output logic              conv_rst_n,
    input  logic              conv_busy_n,
    output logic              conv_oe,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_ovr,
    output logic [GAIN_W-1:0] conv_gain,
    input  logic              gain_wr_en,
    input  logic [GAIN_W-1:0] gain_wr_data,
    output logic              gain_err,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_ovr,
    output logic              smp_settle,
    output logic              fault
);

    logic run, fire, settling;

    adc_host_seq #(
        .RST_CYC     (RST_CYC),
        .FALL_WIN    (FALL_WIN),
        .CAL_TIMEOUT (CAL_TIMEOUT)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_n     (conv_busy_n),
        .conv_rst_n (conv_rst_n),
        .run        (run),
        .fault      (fault)
    );

    adc_host_gain #(
        .GAIN_INIT (GAIN_INIT),
        .SETTLE    (SETTLE)
    ) gain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (gain_wr_en),
        .wr_code  (gain_wr_data),
        .fire     (fire),
        .gain     (conv_gain),
        .gain_err (gain_err),
        .settling (settling)
    );

    adc_host_capture #(
        .DATA_W (DATA_W),
        .OVR_HI (OVR_HI),
        .OVR_LO (OVR_LO)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .conv_data  (conv_data),
        .conv_ovr   (conv_ovr),
        .settling   (settling),
        .fire       (fire),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .smp_ovr    (smp_ovr),
        .smp_settle (smp_settle)
    );

    assign conv_oe = run;

endmodule

// File: rtl/adc_host_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for adc_host_ctrl, attached by bind below.
module adc_host_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_rst_n,
    input logic       conv_oe,
    input logic       smp_valid,
    input logic       fault,
    input logic [2:0] conv_gain,
    input logic       gain_wr_en,
    input logic [2:0] gain_wr_data,
    input logic       gain_err
);

    AST_RST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_rst_n) |-> (!$past(conv_rst_n, 1) && !$past(conv_rst_n, 2) && !$past(conv_rst_n, 3))); // R1

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_rst_n |-> (!conv_oe && !smp_valid)); // R1

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R2

    AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> conv_oe); // R4

    AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        conv_gain != 3'b111); // R7

    AST_WRITE_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr_en && gain_wr_data != 3'b111) |=> (conv_gain == $past(gain_wr_data))); // R7

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr_en && gain_wr_data == 3'b111) |=> ($stable(conv_gain) && gain_err)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        gain_err |=> gain_err); // R8

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!conv_oe && !smp_valid)); // R10

endmodule

bind adc_host_ctrl adc_host_ctrl_chk chk_i (.*);

// File: tb/adc_host_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a converter model drives words and queues expected beats;
// a monitor pops and compares each beat the controller emits.
module adc_host_ctrl_tb_top;

    localparam int RST_CYC = 4;
    localparam int FALL_WIN = 2;
    localparam int CAL_TO = 40;

    typedef struct packed { logic [15:0] d; logic o; logic s; } exp_t;
    typedef struct packed { logic [15:0] w; logic f; } stim_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_rst_n, conv_oe, gain_err, smp_valid, smp_ovr, smp_settle, fault;
    logic        conv_busy_n = 1'b1;
    logic [15:0] conv_data = 16'hzzzz;
    logic        conv_ovr = 1'b0;
    logic [2:0]  conv_gain;
    logic        gain_wr_en = 1'b0;
    logic [2:0]  gain_wr_data = 3'b000;
    logic [15:0] smp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t  exp_q[$];
    stim_t stim_q[$];

    int fall_dly = 1;
    int cal_len = 20;
    int rel_cyc = 0;
    int settle_left = 0;

    always #10 clk = ~clk;

    adc_host_ctrl #(
        .RST_CYC (RST_CYC), .FALL_WIN (FALL_WIN), .CAL_TIMEOUT (CAL_TO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .conv_rst_n (conv_rst_n), .conv_busy_n (conv_busy_n),
        .conv_oe (conv_oe), .conv_data (conv_data), .conv_ovr (conv_ovr),
        .conv_gain (conv_gain), .gain_wr_en (gain_wr_en), .gain_wr_data (gain_wr_data),
        .gain_err (gain_err), .smp_valid (smp_valid), .smp_data (smp_data),
        .smp_ovr (smp_ovr), .smp_settle (smp_settle), .fault (fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Converter model: busy handshake, sample launch, expected-beat driver.
    always @(posedge clk) begin
        #2;
        if (!conv_rst_n) begin
            rel_cyc = 0;
            conv_busy_n = 1'b1;
        end else begin
            rel_cyc++;
            conv_busy_n = !(rel_cyc >= fall_dly && rel_cyc < fall_dly + cal_len);
        end
        if (gain_wr_en && gain_wr_data != 3'b111) settle_left = 6;
        if (conv_oe) begin
            stim_t s;
            exp_t e;
            if (stim_q.size() != 0) s = stim_q.pop_front();
            else begin
                s.w = 16'($urandom);
                s.f = 1'b0;
            end
            conv_data = s.w;
            conv_ovr = s.f;
            e.d = s.w ^ 16'h8000;
            e.o = s.f || (s.w >= 16'hFC00) || (s.w <= 16'h03FF);
            e.s = (settle_left != 0);
            exp_q.push_back(e);
            if (settle_left != 0) settle_left--;
        end else begin
            conv_data = 16'hzzzz;
            conv_ovr = 1'b0;
        end
    end

    // Monitor: compare each emitted beat with the head of the queue.
    always @(posedge clk) begin
        #5;
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) check("R4 unexpected beat", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R5 sample data", {16'd0, smp_data}, {16'd0, e.d});
                check("R6 over-range tag", {31'd0, smp_ovr}, {31'd0, e.o});
                check("R9 settling tag", {31'd0, smp_settle}, {31'd0, e.s});
            end
        end
    end

    task automatic apply_reset();
        @(posedge clk); #3;
        rst_n = 1'b0;
        stim_q.delete();
        repeat (3) @(posedge clk);
        #5;
        exp_q.delete();
        check("R1 conv_rst_n in reset", {31'd0, conv_rst_n}, 32'd0);
        check("R1 conv_oe in reset", {31'd0, conv_oe}, 32'd0);
        check("R1 smp_valid in reset", {31'd0, smp_valid}, 32'd0);
        check("R1 fault in reset", {31'd0, fault}, 32'd0);
        check("R1 R8 gain_err in reset", {31'd0, gain_err}, 32'd0);
        check("R1 gain in reset", {29'd0, conv_gain}, 32'd0);
    endtask

    // Release host reset and count edges until conv_rst_n goes high.
    task automatic release_and_measure();
        int n;
        rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk); #5;
            n++;
        end while (!conv_rst_n && n < 100);
        check("R1 converter reset length", n, RST_CYC);
    endtask

    // Count edges after conv_rst_n rises until run or fault.
    task automatic wait_outcome(output int n);
        n = 0;
        do begin
            @(posedge clk); #5;
            n++;
        end while (!conv_oe && !fault && n < 200);
    endtask

    task automatic gain_write(input logic [2:0] c);
        @(posedge clk); #3;
        gain_wr_en = 1'b1;
        gain_wr_data = c;
        @(posedge clk); #3;
        gain_wr_en = 1'b0;
    endtask

    task automatic push_stim(input logic [15:0] w, input logic f);
        stim_t s;
        s.w = w;
        s.f = f;
        stim_q.push_back(s);
    endtask

    initial begin
        int n;
        logic [2:0] held;

        // Normal bring-up.
        fall_dly = 1; cal_len = 20;
        apply_reset();
        release_and_measure();
        wait_outcome(n);
        check("R3 cycles to run", n, 21);
        check("R2 no fault on normal start", {31'd0, fault}, 32'd0);
        check("R3 output enable in run", {31'd0, conv_oe}, 32'd1);

        // Code corners around the over-range thresholds and full scale.
        push_stim(16'h0000, 1'b0); push_stim(16'h03FF, 1'b0);
        push_stim(16'h0400, 1'b0); push_stim(16'h8000, 1'b0);
        push_stim(16'hFBFF, 1'b0); push_stim(16'hFC00, 1'b0);
        push_stim(16'hFFFF, 1'b0); push_stim(16'h1234, 1'b1);
        push_stim(16'h7FFF, 1'b0);
        repeat (20) @(posedge clk);
        repeat (300) @(posedge clk);

        // Every legal gain code; each restarts settling.
        for (int c = 0; c < 7; c++) begin
            gain_write(3'(c));
            check("R7 gain applied", {29'd0, conv_gain}, c);
            repeat (3 + c) @(posedge clk);
        end
        repeat (12) @(posedge clk);
        gain_write(3'd3);
        held = conv_gain;
        repeat (10) @(posedge clk);
        gain_write(3'b111);
        check("R8 gain kept after reserved code", {29'd0, conv_gain}, {29'd0, held});
        check("R8 gain_err set", {31'd0, gain_err}, 32'd1);
        repeat (15) @(posedge clk);
        check("R8 gain_err sticky", {31'd0, gain_err}, 32'd1);
        gain_write(3'd5);
        gain_write(3'd1);
        repeat (20) @(posedge clk);

        // Busy falls on the last allowed edge.
        fall_dly = 2; cal_len = 20;
        apply_reset();
        release_and_measure();
        wait_outcome(n);
        check("R2 late-but-legal busy, cycles to run", n, 22);
        check("R2 no fault on edge-of-window busy", {31'd0, fault}, 32'd0);
        repeat (30) @(posedge clk);

        // Busy falls one edge too late.
        fall_dly = 3;
        apply_reset();
        release_and_measure();
        wait_outcome(n);
        check("R2 fault edge for missing busy", n, FALL_WIN);
        check("R2 fault raised", {31'd0, fault}, 32'd1);
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #5;
            check("R10 oe low in fault", {31'd0, conv_oe}, 32'd0);
            check("R10 no beats in fault", {31'd0, smp_valid}, 32'd0);
        end
        check("R2 fault held", {31'd0, fault}, 32'd1);

        // Calibration ends on the last allowed edge.
        fall_dly = 1; cal_len = CAL_TO;
        apply_reset();
        release_and_measure();
        wait_outcome(n);
        check("R3 run at timeout boundary", n, 1 + CAL_TO);
        check("R3 no fault at timeout boundary", {31'd0, fault}, 32'd0);
        repeat (20) @(posedge clk);

        // Calibration overruns by one edge.
        cal_len = CAL_TO + 1;
        apply_reset();
        release_and_measure();
        wait_outcome(n);
        check("R3 fault edge on calibration overrun", n, 1 + CAL_TO);
        check("R3 fault raised on overrun", {31'd0, fault}, 32'd1);
        check("R10 oe low after overrun", {31'd0, conv_oe}, 32'd0);
        repeat (10) @(posedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule